// File: doc/BRIEF.md
# Power-Fail Backup and Restore Sequencer

This controller keeps the contents of a volatile memory array across a loss of main power. In normal running the host owns the array through an external bus multiplexer, and the non-volatile banks sit idle. When the host raises a power-fail alert on the sideband, the controller first takes the array away from the host. It then reads every word and spreads the words across a set of non-volatile banks that accept writes in parallel. When every bank has accepted its last word, the controller marks the saved image valid and parks in a halted state.

When system power comes back (power-good seen low, then high again), the controller raises busy and reads each bank back. It rewrites the array in ascending address order. It then waits for the backup energy store to report that it is charged, drops busy, raises ready and hands the array back to the host. A reset is treated as a cold power-up with no saved image, so the controller passes through busy straight to ready and raises a restore-error flag. A fault reported by the energy store is passed on to the host on a status output.

Word i goes to bank (i mod NBANK) at bank-local address (i div NBANK). Each bank uses its own valid/ready handshake for writes and for reads, and a bank may stall for any number of cycles.

Top module: `pfail_seq`

## Requirements
- R1: While reset is held, host_sel, ready and busy are 0, and every nv_wr_valid and nv_rd_ready bit is 0; reset is treated as a cold power-up in the halted state.
- R2: While host_sel is 1, the controller asserts no array read or write and no bank write-valid or read-ready.
- R3: A pf_alert sampled while ready is 1 drops host_sel at the next clock edge, and va_rd_en is never 1 while host_sel is 1.
- R4: During a save, bank b receives at local address k exactly the array word at address k*NBANK+b.
- R5: Under arbitrary per-bank write stalls, each bank accepts exactly DEPTH/NBANK writes, at local addresses 0, 1, 2... in order, with no word lost or repeated.
- R6: After the last bank write is accepted, the controller halts (host_sel, busy and ready all 0) and stays halted until pwr_good has been 0 and is 1 again.
- R7: pf_alert is ignored in every state except the one with ready at 1: during a save, in halt and during recovery it changes neither the outputs nor the transfer.
- R8: The clock edge that samples power return while halted raises busy, and busy stays 1 until the cycle in which ready rises; busy and ready are never both 1.
- R9: Recovery writes array addresses 0..DEPTH-1 in ascending order, each with the word saved for that address.
- R10: After the last restore write, ready stays 0 until store_charged is sampled 1, and ready rises at the edge that samples it.
- R11: Power return with no valid saved image gives busy for one cycle, then ready with restore_err at 1 and no bank reads. restore_err clears when the next alert is accepted.
- R12: energy_fault shows store_fault as sampled at the previous clock edge, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (cold power-up) |
| pf_alert | input | 1 | Sideband power-fail alert from the host |
| pwr_good | input | 1 | System power present |
| store_charged | input | 1 | Backup energy store reports charged |
| store_fault | input | 1 | Backup energy store reports a fault |
| host_sel | output | 1 | Array mux select: 1 = host owns the array |
| busy | output | 1 | Sideband busy during recovery |
| ready | output | 1 | Sideband ready: host may use the array |
| energy_fault | output | 1 | Registered energy-store fault status |
| restore_err | output | 1 | Recovery found no valid saved image |
| va_rd_en | output | 1 | Array read strobe (data one cycle later) |
| va_wr_en | output | 1 | Array write strobe |
| va_addr | output | $clog2(DEPTH) | Array word address |
| va_wr_data | output | DW | Array write data |
| va_rd_data | input | DW | Array read data |
| nv_wr_valid | output | NBANK | Per-bank write valid |
| nv_wr_ready | input | NBANK | Per-bank write ready |
| nv_wr_addr | output | NBANK*$clog2(DEPTH/NBANK) | Per-bank local write address |
| nv_wr_data | output | NBANK*DW | Per-bank write data |
| nv_rd_ready | output | NBANK | Per-bank read request (controller ready for a word) |
| nv_rd_valid | input | NBANK | Per-bank read data valid |
| nv_rd_addr | output | NBANK*$clog2(DEPTH/NBANK) | Per-bank local read address |
| nv_rd_data | input | NBANK*DW | Per-bank read data |

## Verification
The hardest situation to reach is a bank that stalls while its neighbours run ahead. The interleaved issue then has to wait on one slow lane with a read already in flight, and recovery has to hold its ascending write order while the other lanes sit full. The bench reaches it by giving every bank its own handshake rhythm, derived from the cycle count and a per-round seed, and it changes the seed each round. Each round also pulses pf_alert in the middle of the save, in halt and in the middle of recovery. A controller that restarted on one of these pulses would show up as extra bank writes or as addresses out of order.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

    typedef enum logic [2:0] {
        ST_HOST   = 3'd0,
        ST_SAVE   = 3'd1,
        ST_HALT   = 3'd2,
        ST_LOAD   = 3'd3,
        ST_CHARGE = 3'd4
    } pf_state_e;

    function automatic logic in_recovery(input pf_state_e s);
        return (s == ST_LOAD) || (s == ST_CHARGE);
    endfunction

endpackage

// File: rtl/pfail_lane.sv
module pfail_lane #(
    parameter int DW     = 16,
    parameter int LDEPTH = 8,
    localparam int LAW   = $clog2(LDEPTH),
    localparam int PW    = $clog2(LDEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           save_en,
    input  logic           load_en,
    input  logic           put,
    input  logic [DW-1:0]  put_data,
    input  logic           take,
    output logic           full,
    output logic [DW-1:0]  slot_data,
    output logic           wr_valid,
    input  logic           wr_ready,
    output logic [LAW-1:0] wr_addr,
    output logic [DW-1:0]  wr_data,
    output logic           rd_ready,
    input  logic           rd_valid,
    output logic [LAW-1:0] rd_addr,
    input  logic [DW-1:0]  rd_data
);

    logic          slot_v;
    logic [DW-1:0] slot_d;
    logic [PW-1:0] ptr;

    assign full      = slot_v;
    assign slot_data = slot_d;
    assign wr_valid  = save_en && slot_v;
    assign wr_addr   = ptr[LAW-1:0];
    assign wr_data   = slot_d;
    assign rd_ready  = load_en && !slot_v && (ptr < PW'(LDEPTH));
    assign rd_addr   = ptr[LAW-1:0];

    always_ff @(posedge clk) begin
        if (rst || !(save_en || load_en)) begin
            slot_v <= 1'b0;
            slot_d <= '0;
            ptr    <= '0;
        end else if (save_en) begin
            if (put) begin
                slot_v <= 1'b1;
                slot_d <= put_data;
            end else if (slot_v && wr_ready) begin
                slot_v <= 1'b0;
                ptr    <= ptr + 1'b1;
            end
        end else begin
            if (rd_ready && rd_valid) begin
                slot_v <= 1'b1;
                slot_d <= rd_data;
                ptr    <= ptr + 1'b1;
            end else if (take) begin
                slot_v <= 1'b0;
            end
        end
    end

    AST_PUT_INTO_EMPTY: assert property (@(posedge clk) disable iff (rst)
        put |-> !slot_v); // R5
    AST_TAKE_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
        take |-> slot_v); // R9
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr <= PW'(LDEPTH)); // R5

endmodule

// File: rtl/pfail_seq.sv
module pfail_seq
    import pfail_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int NBANK = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LAW  = $clog2(DEPTH / NBANK)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pf_alert,
    input  logic                 pwr_good,
    input  logic                 store_charged,
    input  logic                 store_fault,
    output logic                 host_sel,
    output logic                 busy,
    output logic                 ready,
    output logic                 energy_fault,
    output logic                 restore_err,
    output logic                 va_rd_en,
    output logic                 va_wr_en,
    output logic [AW-1:0]        va_addr,
    output logic [DW-1:0]        va_wr_data,
    input  logic [DW-1:0]        va_rd_data,
    output logic [NBANK-1:0]     nv_wr_valid,
    input  logic [NBANK-1:0]     nv_wr_ready,
    output logic [NBANK*LAW-1:0] nv_wr_addr,
    output logic [NBANK*DW-1:0]  nv_wr_data,
    output logic [NBANK-1:0]     nv_rd_ready,
    input  logic [NBANK-1:0]     nv_rd_valid,
    output logic [NBANK*LAW-1:0] nv_rd_addr,
    input  logic [NBANK*DW-1:0]  nv_rd_data
);

    localparam int LDEPTH = DEPTH / NBANK;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int BW     = $clog2(NBANK);

    pf_state_e      state;
    logic           pwr_lost;
    logic           img_valid;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  bsel;
    logic           ld_v;
    logic [BW-1:0]  ld_bank;

    logic [NBANK-1:0] lane_full;
    logic [DW-1:0]    lane_data [NBANK];
    logic [NBANK-1:0] lane_put;
    logic [NBANK-1:0] lane_take;
    logic             lane_save;
    logic             lane_load;
    logic             issue;
    logic             wtake;
    logic             all_words;
    logic             save_done;

    assign all_words  = (cnt == CW'(DEPTH));
    assign lane_save  = (state == ST_SAVE);
    assign lane_load  = (state == ST_LOAD) && img_valid;
    assign issue      = lane_save && !all_words && !lane_full[bsel];
    assign wtake      = lane_load && !all_words && lane_full[bsel];
    assign save_done  = lane_save && all_words && !ld_v && (lane_full == '0);

    assign host_sel   = (state == ST_HOST);
    assign ready      = (state == ST_HOST);
    assign busy       = in_recovery(state);
    assign va_rd_en   = issue;
    assign va_wr_en   = wtake;
    assign va_addr    = cnt[AW-1:0];
    assign va_wr_data = lane_data[bsel];

    for (genvar b = 0; b < NBANK; b++) begin : g_lane
        assign lane_put[b]  = ld_v && (ld_bank == BW'(b));
        assign lane_take[b] = wtake && (bsel == BW'(b));

        pfail_lane #(.DW(DW), .LDEPTH(LDEPTH)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .save_en   (lane_save),
            .load_en   (lane_load),
            .put       (lane_put[b]),
            .put_data  (va_rd_data),
            .take      (lane_take[b]),
            .full      (lane_full[b]),
            .slot_data (lane_data[b]),
            .wr_valid  (nv_wr_valid[b]),
            .wr_ready  (nv_wr_ready[b]),
            .wr_addr   (nv_wr_addr[b*LAW +: LAW]),
            .wr_data   (nv_wr_data[b*DW +: DW]),
            .rd_ready  (nv_rd_ready[b]),
            .rd_valid  (nv_rd_valid[b]),
            .rd_addr   (nv_rd_addr[b*LAW +: LAW]),
            .rd_data   (nv_rd_data[b*DW +: DW])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_HALT;
            pwr_lost     <= 1'b1;
            img_valid    <= 1'b0;
            restore_err  <= 1'b0;
            energy_fault <= 1'b0;
            cnt          <= '0;
            bsel         <= '0;
            ld_v         <= 1'b0;
            ld_bank      <= '0;
        end else begin
            energy_fault <= store_fault;
            ld_v         <= issue;
            if (issue) ld_bank <= bsel;
            if (issue || wtake) begin
                cnt  <= cnt + 1'b1;
                bsel <= (bsel == BW'(NBANK - 1)) ? '0 : bsel + 1'b1;
            end
            case (state)
                ST_HOST: if (pf_alert) begin
                    state       <= ST_SAVE;
                    img_valid   <= 1'b0;
                    restore_err <= 1'b0;
                    pwr_lost    <= 1'b0;
                    cnt         <= '0;
                    bsel        <= '0;
                end
                ST_SAVE: begin
                    if (!pwr_good) pwr_lost <= 1'b1;
                    if (save_done) begin
                        state     <= ST_HALT;
                        img_valid <= 1'b1;
                    end
                end
                ST_HALT: begin
                    if (!pwr_good) begin
                        pwr_lost <= 1'b1;
                    end else if (pwr_lost) begin
                        state    <= ST_LOAD;
                        pwr_lost <= 1'b0;
                        cnt      <= '0;
                        bsel     <= '0;
                    end
                end
                ST_LOAD: begin
                    if (!img_valid) begin
                        state       <= ST_HOST;
                        restore_err <= 1'b1;
                    end else if (wtake && cnt == CW'(DEPTH - 1)) begin
                        state <= ST_CHARGE;
                    end
                end
                ST_CHARGE: if (store_charged) state <= ST_HOST;
                default: state <= ST_HALT;
            endcase
        end
    end

    AST_NO_READ_WHILE_HOST: assert property (@(posedge clk) disable iff (rst)
        va_rd_en |-> !host_sel); // R3
    AST_HOST_QUIET: assert property (@(posedge clk) disable iff (rst)
        host_sel |-> (!va_wr_en && nv_wr_valid == '0 && nv_rd_ready == '0)); // R2
    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && ready)); // R8
    AST_BUSY_ENDS_IN_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ready); // R8
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !pwr_lost) |=> (state == ST_HALT)); // R6
    AST_READY_AFTER_CHARGE: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && $past(state) == ST_CHARGE) |-> $past(store_charged)); // R10
    AST_NO_READ_WITHOUT_IMAGE: assert property (@(posedge clk) disable iff (rst)
        !img_valid |-> (nv_rd_ready == '0)); // R11

endmodule

// File: tb/pfail_seq_test.sv
`timescale 1ns/1ps
module pfail_seq_test;

    localparam int DW = 8;
    localparam int DEPTH = 32;
    localparam int NB = 4;
    localparam int LD = DEPTH / NB;
    localparam int AW = $clog2(DEPTH);
    localparam int LAW = $clog2(LD);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pf_alert = 1'b0, pwr_good = 1'b1, store_charged = 1'b0, store_fault = 1'b0;
    logic host_sel, busy, ready, energy_fault, restore_err;
    logic va_rd_en, va_wr_en;
    logic [AW-1:0] va_addr;
    logic [DW-1:0] va_wr_data, va_rd_data;
    logic [NB-1:0] nv_wr_valid, nv_wr_ready, nv_rd_ready, nv_rd_valid;
    logic [NB*LAW-1:0] nv_wr_addr, nv_rd_addr;
    logic [NB*DW-1:0] nv_wr_data, nv_rd_data;

    always #2.5 clk = ~clk;

    pfail_seq #(.DW(DW), .DEPTH(DEPTH), .NBANK(NB)) uut (
        .clk(clk), .rst(rst), .pf_alert(pf_alert), .pwr_good(pwr_good),
        .store_charged(store_charged), .store_fault(store_fault),
        .host_sel(host_sel), .busy(busy), .ready(ready),
        .energy_fault(energy_fault), .restore_err(restore_err),
        .va_rd_en(va_rd_en), .va_wr_en(va_wr_en), .va_addr(va_addr),
        .va_wr_data(va_wr_data), .va_rd_data(va_rd_data),
        .nv_wr_valid(nv_wr_valid), .nv_wr_ready(nv_wr_ready),
        .nv_wr_addr(nv_wr_addr), .nv_wr_data(nv_wr_data),
        .nv_rd_ready(nv_rd_ready), .nv_rd_valid(nv_rd_valid),
        .nv_rd_addr(nv_rd_addr), .nv_rd_data(nv_rd_data)
    );

    int total = 0, fails = 0, cyc = 0, seed = 0, round = 0;
    logic [DW-1:0] amem [DEPTH];
    logic [DW-1:0] bmem [NB][LD];
    int wr_cnt [NB];
    int wr_sum = 0, wr_bad = 0, rd_total = 0, exp_w = 0, order_bad = 0, rest_bad = 0;
    int bad_rd = 0, host_viol = 0;

    function automatic logic [DW-1:0] pat(input int i, input int r);
        return DW'((i * 37 + r * 11 + 5) & 255);
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++; total++;
            $display("FAIL watchdog (all requirements) actual=expired expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            nv_wr_ready[b] = ((cyc + 3 * b + seed) % (b + 2 + seed)) == 0;
            nv_rd_valid[b] = ((cyc + b + 2 * seed) % (3 + seed)) != 1;
            nv_rd_data[b*DW +: DW] = bmem[b][nv_rd_addr[b*LAW +: LAW]];
        end
    end

    always @(posedge clk) begin
        if (va_rd_en) va_rd_data <= amem[va_addr];
        if (va_wr_en) amem[va_addr] <= va_wr_data;
        for (int b = 0; b < NB; b++)
            if (nv_wr_valid[b] && nv_wr_ready[b])
                bmem[b][nv_wr_addr[b*LAW +: LAW]] <= nv_wr_data[b*DW +: DW];
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (va_rd_en && host_sel) bad_rd++;
            if (host_sel && (va_rd_en || va_wr_en || (|nv_wr_valid) || (|nv_rd_ready))) host_viol++;
            for (int b = 0; b < NB; b++) begin
                if (nv_wr_valid[b] && nv_wr_ready[b]) begin
                    if (int'(nv_wr_addr[b*LAW +: LAW]) != wr_cnt[b]) wr_bad++;
                    if (nv_wr_data[b*DW +: DW] != pat(wr_cnt[b] * NB + b, round)) wr_bad++;
                    wr_cnt[b]++;
                    wr_sum++;
                end
                if (nv_rd_ready[b] && nv_rd_valid[b]) rd_total++;
            end
            if (va_wr_en) begin
                if (int'(va_addr) != exp_w) order_bad++;
                if (va_wr_data != pat(exp_w, round)) rest_bad++;
                exp_w++;
            end
        end
    end

    task automatic pulse_alert();
        pf_alert = 1'b1;
        @(negedge clk);
        pf_alert = 1'b0;
    endtask

    task automatic run_round(input int r);
        int guard;
        int still;
        round = r; seed = r;
        for (int i = 0; i < DEPTH; i++) amem[i] = pat(i, r);
        for (int b = 0; b < NB; b++) wr_cnt[b] = 0;
        wr_sum = 0; wr_bad = 0; exp_w = 0; order_bad = 0; rest_bad = 0; host_viol = 0;
        repeat (8) @(negedge clk);
        check(host_viol == 0, "R2 host mode quiet", host_viol, 0);
        pulse_alert();
        check(host_sel == 1'b0, "R3 mux taken after alert", int'(host_sel), 0);
        check(restore_err == 1'b0, "R11 error cleared by alert", int'(restore_err), 0);
        repeat (3) @(negedge clk);
        pulse_alert();
        guard = 0;
        while (wr_sum < DEPTH && guard < 5000) begin @(negedge clk); guard++; end
        check(guard < 5000, "R5 save finished", guard, 0);
        repeat (3) @(negedge clk);
        check(wr_bad == 0, "R4 bank word mapping", wr_bad, 0);
        for (int b = 0; b < NB; b++)
            check(wr_cnt[b] == LD, "R5 writes per bank", wr_cnt[b], LD);
        check(bad_rd == 0, "R3 no read while host owns array", bad_rd, 0);
        still = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (busy || ready || host_sel || va_wr_en) still++;
        end
        check(still == 0, "R6 halt holds with power good", still, 0);
        pwr_good = 1'b0;
        @(negedge clk);
        pulse_alert();
        for (int i = 0; i < DEPTH; i++) amem[i] = '0;
        repeat (4) @(negedge clk);
        check(!host_sel && !busy && !ready, "R7 alert ignored in halt", int'({host_sel, busy, ready}), 0);
        store_charged = 1'b0;
        pwr_good = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R8 busy on power return", int'(busy), 1);
        pulse_alert();
        guard = 0; still = 0;
        while (exp_w < DEPTH && guard < 5000) begin
            if (!busy) still++;
            @(negedge clk); guard++;
        end
        check(guard < 5000 && still == 0, "R8 busy held during restore", still, 0);
        still = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!busy || ready) still++;
        end
        check(still == 0, "R10 ready waits for charge", still, 0);
        check(order_bad == 0 && rest_bad == 0, "R9 restore order and data", order_bad + rest_bad, 0);
        still = 0;
        for (int i = 0; i < DEPTH; i++) if (amem[i] != pat(i, r)) still++;
        check(still == 0, "R9 array contents restored", still, 0);
        check(host_sel == 1'b0, "R7 alert ignored in recovery", int'(host_sel), 0);
        store_charged = 1'b1;
        @(negedge clk);
        check(ready && !busy && host_sel, "R10 ready on charge", int'({ready, busy, host_sel}), 5);
        check(restore_err == 1'b0, "R11 no error with image", int'(restore_err), 0);
        store_charged = 1'b0;
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            wr_cnt[b] = 0;
            for (int k = 0; k < LD; k++) bmem[b][k] = '0;
        end
        for (int i = 0; i < DEPTH; i++) amem[i] = '0;
        repeat (3) @(negedge clk);
        check(!host_sel && !ready && !busy, "R1 reset outputs", int'({host_sel, ready, busy}), 0);
        check(nv_wr_valid == '0 && nv_rd_ready == '0, "R1 banks idle in reset",
              int'({nv_wr_valid, nv_rd_ready}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy && !ready, "R8 busy first on cold start", int'({busy, ready}), 2);
        @(negedge clk);
        check(ready && !busy && restore_err, "R11 ready with error, no image",
              int'({ready, busy, restore_err}), 5);
        check(rd_total == 0, "R11 no bank reads without image", rd_total, 0);
        store_fault = 1'b1;
        @(negedge clk);
        check(energy_fault == 1'b1, "R12 fault reported", int'(energy_fault), 1);
        store_fault = 1'b0;
        @(negedge clk);
        check(energy_fault == 1'b0, "R12 fault cleared", int'(energy_fault), 0);
        for (int r = 0; r < 3; r++) run_round(r);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule